// File: doc/BRIEF.md
# Dual-Mode Serial Result Framer

This block is the digital output side of a 14-bit sampling converter. A modelled converter core captures a 14-bit code and an out-of-range flag when a conversion starts, and publishes them as the current result a fixed number of master clocks later. The framer sends that result on a single serial data line. The line is timed by a serial clock that is derived from the master clock. The receiver captures each bit on the falling serial-clock edge.

Two framing modes are available. With the mode input low, the active-low convert-start line both starts a conversion and frames the serial data. With the mode input high, convert-start only starts conversions. A separate active-low frame-sync input then frames the data, and it may be held low permanently. Every frame carries the result of the conversion that finished before it. The frame that runs during a conversion therefore carries the previous sample. The data line has its own enable output for a three-state pad.

Top module: `sar_frame_tx`

## Requirements
- R1: With mode_i = 0, conv_n_i frames the data. Pulses on conv_n_i while mode_i = 1 and fs_n_i = 1 leave sdo_en_o low.
- R2: A frame has 16 slots, sent in this order: the overrange flag, then the 14 code bits from bit 13 down to bit 0, then a single 0.
- R3: sclk_o toggles on every master clock edge and is 0 during reset. The first slot is launched on the first rising sclk_o edge after the edge that samples the framing fall. Each later slot is launched on the next rising edge, and sdo_o changes only on such edges or when a frame starts or ends.
- R4: sdo_en_o is 1 from the clock after the framing input is sampled low until the clock after it is sampled high.
- R5: A conversion starts on a sampled falling edge of conv_n_i and completes CONV_CYCLES master clocks later. A frame carries the most recently completed result, and all zeros if no conversion has completed since reset.
- R6: With mode_i = 1, a falling edge of fs_n_i starts a frame.
- R7: With mode_i = 1 and fs_n_i held low, sdo_en_o stays 1, and each conversion start begins a new frame from the overrange slot.
- R8: A frame that ends before all 16 slots are sent clears the slot pointer. The next frame starts again at the overrange slot.
- R9: During reset, sclk_o, sdo_o and sdo_en_o are 0.
- R10: After the 16th slot, sdo_o stays 0 while the frame remains open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Framing mode: 0 convert-start framing, 1 frame-sync framing |
| conv_n_i | input | 1 | Convert start, active low, falling edge starts a conversion |
| fs_n_i | input | 1 | Frame sync, active low, used when mode_i = 1 |
| core_code_i | input | 14 | Code presented by the converter core model |
| core_ovr_i | input | 1 | Out-of-range flag from the converter core model |
| sclk_o | output | 1 | Serial clock, master clock divided by two |
| sdo_o | output | 1 | Serial data |
| sdo_en_o | output | 1 | Output enable for the three-state data pad |

## Verification
On every cycle, the assertions check four things. The data line moves only on a rising serial clock or at a frame boundary. The enable follows the selected framing input and ignores the other one. The slot pointer stays clear while the line is released, and the line stays low once the trailing slot has gone out. The published result changes only when a conversion completes. The bench scenarios are needed to show the slot order and bit values, the one-sample latency, the all-zero first frame, the restart after a truncated frame, and repeated frames with frame-sync tied low.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int unsigned CODE_W = 14;
  localparam int unsigned SLOTS  = CODE_W + 2;

  typedef struct packed {
    logic              ovr;
    logic [CODE_W-1:0] code;
  } sft_result_t;
endpackage

// File: rtl/sft_sclk_gen.sv
module sft_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;
  // next master edge produces a rising serial edge
  assign rise_o = ~sclk_q;
endmodule

// File: rtl/sft_conv_model.sv
module sft_conv_model import sft_pkg::*; #(
  parameter int unsigned CONV_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_n_i,
  input  logic [CODE_W-1:0] core_code_i,
  input  logic              core_ovr_i,
  output logic              start_o,
  output sft_result_t       result_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES);

  logic              cv_d;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  sft_result_t       samp_q, res_q;

  assign start_o  = cv_d & ~conv_n_i & ~busy_q;
  assign result_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_d   <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      samp_q <= '0;
      res_q  <= '0;
    end else begin
      cv_d <= conv_n_i;
      if (start_o) begin
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        samp_q.ovr  <= core_ovr_i;
        samp_q.code <= core_code_i;
      end else if (busy_q) begin
        if (cnt_q == CNT_W'(CONV_CYCLES - 1)) begin
          busy_q <= 1'b0;
          res_q  <= samp_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> $past(busy_q));
endmodule

// File: rtl/sft_shifter.sv
module sft_shifter import sft_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_n_i,
  input  logic             start_i,
  input  logic             rise_i,
  input  logic [SLOTS-1:0] word_i,
  output logic             sdo_o,
  output logic             sdo_en_o
);
  localparam int unsigned PTR_W = $clog2(SLOTS + 1);

  logic             active_q, en_q, sdo_q;
  logic [PTR_W-1:0] ptr_q;
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      en_q     <= 1'b0;
      sdo_q    <= 1'b0;
      ptr_q    <= '0;
      sh_q     <= '0;
    end else begin
      en_q <= ~frame_n_i;
      if (frame_n_i) begin
        active_q <= 1'b0;
        ptr_q    <= '0;
        sdo_q    <= 1'b0;
      end else if (start_i) begin
        active_q <= 1'b1;
        ptr_q    <= '0;
        sh_q     <= word_i;
      end else if (active_q && rise_i) begin
        if (ptr_q < PTR_W'(SLOTS)) begin
          sdo_q <= sh_q[SLOTS-1];
          sh_q  <= {sh_q[SLOTS-2:0], 1'b0};
          ptr_q <= ptr_q + 1'b1;
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = en_q;

  // R10
  tail_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_W'(SLOTS)) |-> !sdo_q);
  // R8
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (ptr_q == '0) && !sdo_q);
endmodule

// File: rtl/sar_frame_tx.sv
module sar_frame_tx import sft_pkg::*; #(
  parameter int unsigned CONV_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              conv_n_i,
  input  logic              fs_n_i,
  input  logic [CODE_W-1:0] core_code_i,
  input  logic              core_ovr_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  logic             rise, conv_start, frame_n, fr_d, frame_start;
  sft_result_t      result;
  logic [SLOTS-1:0] word;

  sft_sclk_gen u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_o (sclk_o),
    .rise_o (rise)
  );

  sft_conv_model #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_n_i    (conv_n_i),
    .core_code_i (core_code_i),
    .core_ovr_i  (core_ovr_i),
    .start_o     (conv_start),
    .result_o    (result)
  );

  assign frame_n = mode_i ? fs_n_i : conv_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fr_d <= 1'b1;
    else         fr_d <= frame_n;
  end

  // mode 2 with frame-sync already low: each conversion start reframes
  assign frame_start = (fr_d & ~frame_n) | (mode_i & ~frame_n & conv_start);
  assign word        = {result.ovr, result.code, 1'b0};

  sft_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_n_i (frame_n),
    .start_i   (frame_start),
    .rise_i    (rise),
    .word_i    (word),
    .sdo_o     (sdo_o),
    .sdo_en_o  (sdo_en_o)
  );

  // R3
  sdo_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $rose(sclk_o) || $past(frame_start) || !sdo_en_o);
  // R1
  conv_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && conv_n_i) |=> !sdo_en_o);
  // R6
  fs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && fs_n_i) |=> !sdo_en_o);
endmodule

// File: tb/sar_frame_tx_bench.sv
module sar_frame_tx_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0, conv_n_i = 1'b1, fs_n_i = 1'b1;
  logic [13:0] core_code_i = '0;
  logic        core_ovr_i = 1'b0;
  logic        sclk_o, sdo_o, sdo_en_o;

  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  logic [14:0] model_res = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sar_frame_tx u_sar_frame_tx (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .conv_n_i(conv_n_i),
    .fs_n_i(fs_n_i), .core_code_i(core_code_i), .core_ovr_i(core_ovr_i),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: collects one frame per queued expectation
  initial begin : mon
    logic [15:0] exp_w, got;
    forever begin
      wait (exp_q.size() > 0);
      exp_w = exp_q.pop_front();
      got = '0;
      @(posedge clk);  // edge that samples the framing fall
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
        do @(negedge clk); while (!sclk_o);
        got = {got[14:0], sdo_o};
        chk(sdo_en_o, "R4 enable during slot", sdo_en_o, 1);
      end
      chk(got == exp_w, "R2/R5 frame word", got, exp_w);
      repeat (3) @(negedge clk);
      chk(!sdo_o && sdo_en_o, "R10 line low after last slot", {sdo_en_o, sdo_o}, 2);
    end
  end

  task automatic m1_frame(input logic [13:0] c, input logic o);
    core_code_i = c; core_ovr_i = o;
    exp_q.push_back({model_res, 1'b0});
    conv_n_i = 1'b0;
    repeat (44) @(negedge clk);
    conv_n_i = 1'b1;
    model_res = {o, c};
    repeat (2) @(negedge clk);
    chk(!sdo_en_o, "R4 released after convert-start high", sdo_en_o, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic conv_pulse(input logic [13:0] c, input logic o, input bit expect_frame);
    core_code_i = c; core_ovr_i = o;
    if (expect_frame) exp_q.push_back({model_res, 1'b0});
    conv_n_i = 1'b0;
    repeat (2) @(negedge clk);
    conv_n_i = 1'b1;
    model_res = {o, c};
  endtask

  task automatic fs_frame(input bit expect_frame, input int len);
    if (expect_frame) exp_q.push_back({model_res, 1'b0});
    fs_n_i = 1'b0;
    repeat (len) @(negedge clk);
    fs_n_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sdo_en_o, "R4 released after frame-sync high", sdo_en_o, 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : drv
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!sclk_o, "R9 sclk in reset", sclk_o, 0);
    chk(!sdo_o, "R9 sdo in reset", sdo_o, 0);
    chk(!sdo_en_o, "R9 enable in reset", sdo_en_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R5: first frame zeros, then one-sample latency
    m1_frame(14'h2A5C, 1'b0);
    m1_frame(14'h3FFF, 1'b1);
    m1_frame(14'h0001, 1'b0);

    // R1: conversion pulse in mode 2 with frame-sync high keeps line released
    mode_i = 1'b1;
    repeat (2) @(negedge clk);
    core_code_i = 14'h1234; core_ovr_i = 1'b1;
    conv_n_i = 1'b0;
    @(negedge clk);
    chk(!sdo_en_o, "R1 conv ignored for framing in mode 2", sdo_en_o, 0);
    @(negedge clk);
    conv_n_i = 1'b1;
    model_res = {1'b1, 14'h1234};
    repeat (2) @(negedge clk);
    chk(!sdo_en_o, "R1 line still released", sdo_en_o, 0);
    repeat (30) @(negedge clk);

    // R6: frame-sync framed read
    fs_frame(1'b1, 44);

    // R8: truncated frame then full frame restarting at overrange slot
    conv_pulse(14'h0AAA, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    fs_frame(1'b0, 12);
    fs_frame(1'b1, 44);

    // R7: frame-sync tied low
    fs_n_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(sdo_en_o, "R7 line driven while frame-sync low", sdo_en_o, 1);
    conv_pulse(14'h3001, 1'b1, 1'b1);
    repeat (42) @(negedge clk);
    chk(sdo_en_o, "R7 line still driven", sdo_en_o, 1);
    conv_pulse(14'h0F0F, 1'b0, 1'b1);
    repeat (42) @(negedge clk);
    chk(sdo_en_o, "R7 line driven after second frame", sdo_en_o, 1);
    fs_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all frames consumed", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule